// File: doc/BRIEF.md
# USB Transceiver Host-Side Mode Logic

This block is the digital steering layer between a host USB link controller and the line drivers and receivers of a full/low-speed transceiver. Two strap inputs select one of four host-side styles. One selects a VP/VM pin pair or a DAT/SE0 pair. The other selects bidirectional pins or transmit-only pins. In each style the block turns the host's transmit pins into driver data and a driver enable. It also returns the digital images of the DP, DM and differential receivers to the host.

A three-bit bus mode register selects what the shared lines carry. The choices are USB, two UART variants, mono audio, stereo audio and two loopback test codes. The register resets to USB, and the transceiver is enabled only in that mode. While an audio mode is active, a strobe requests a single timed positive pulse on DM, which tells an accessory to leave audio mode. The request bit clears itself when the pulse ends.

Top module: `usb_xcvr_if_ctl`

## Requirements
- R1: The bus mode register resets to 3'b000 (USB) and loads `mode_wdata` on a cycle with `mode_we` high. `xcvr_en` is high only while the register holds 3'b000 and `rst_n` is high.
- R2: In VP/VM bidirectional style (`cfg_se0_style`=0, `cfg_bidir`=1), with the transceiver enabled and `txen_n`=1, `dat_vp_out`=`rx_dp`, `se0_vm_out`=`rx_dm`, and both `dat_vp_oe` and `se0_vm_oe` are 1.
- R3: In DAT/SE0 bidirectional style (`cfg_se0_style`=1, `cfg_bidir`=1), with the transceiver enabled and `txen_n`=1, `dat_vp_out`=`rx_dp` and `se0_vm_out` is 1 exactly when `rx_dp` and `rx_dm` are both 0. Both pin enables are 1.
- R4: With `cfg_bidir`=0, `dat_vp_oe` and `se0_vm_oe` are always 0.
- R5: With the transceiver enabled, `vp_out`=`rx_dp`, `vm_out`=`rx_dm` and `rcv_out`=`rx_diff`, whatever the value of `txen_n`.
- R6: In VP/VM style, with the transceiver enabled and `txen_n`=0, `drv_oe`=1, `drv_dp`=`dat_vp_in` and `drv_dm`=`se0_vm_in`. The bidirectional pin enables are 0.
- R7: In DAT/SE0 style, with the transceiver enabled and `txen_n`=0, `drv_oe`=1. `se0_vm_in`=1 gives `drv_dp`=`drv_dm`=0. Otherwise `drv_dp`=`dat_vp_in` and `drv_dm`=NOT `dat_vp_in`.
- R8: `drv_oe`, `drv_dp` and `drv_dm` are 0 in every mode other than 3'b000, and also whenever `txen_n`=1.
- R9: In the UART modes 3'b001 and 3'b010, `vp_out`=`rx_dp` and `vm_out`=`rx_dm`. `rcv_out` and both pin enables are 0.
- R10: In the audio modes 3'b100 and 3'b101, and in the unused code 3'b011, `vp_out`, `vm_out`, `rcv_out`, `dat_vp_oe` and `se0_vm_oe` are all 0.
- R11: In the loopback modes 3'b110 and 3'b111, `vp_out`=`dat_vp_in` and `vm_out`=`se0_vm_in`.
- R12: A `dm_pulse_set` strobe seen at a clock edge while the mode is 3'b100 or 3'b101 raises `dm_pulse_out` after that edge. The output stays high for exactly `PULSE_CYC` cycles and then clears itself. The default of 40 cycles at 125 MHz gives 320 ns, which lies inside the 200 to 500 ns window.
- R13: A `dm_pulse_set` strobe has no effect on `dm_pulse_out` in any non-audio mode. A strobe that arrives while a pulse is already running does not lengthen that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_we | input | 1 | Bus mode register write strobe |
| mode_wdata | input | 3 | Bus mode value to load |
| cfg_se0_style | input | 1 | 1 = DAT/SE0 pin style, 0 = VP/VM pin style |
| cfg_bidir | input | 1 | 1 = bidirectional host pins, 0 = transmit-only host pins |
| txen_n | input | 1 | Host transmit enable, active low |
| dat_vp_in | input | 1 | Host data / VP pin, transmit value |
| se0_vm_in | input | 1 | Host SE0 / VM pin, transmit value |
| rx_dp | input | 1 | DP single-ended receiver image |
| rx_dm | input | 1 | DM single-ended receiver image |
| rx_diff | input | 1 | Differential receiver image |
| dm_pulse_set | input | 1 | Request for the DM exit pulse |
| dat_vp_out | output | 1 | Receive value for the host data / VP pin |
| dat_vp_oe | output | 1 | Drive enable of the host data / VP pin |
| se0_vm_out | output | 1 | Receive value for the host SE0 / VM pin |
| se0_vm_oe | output | 1 | Drive enable of the host SE0 / VM pin |
| vp_out | output | 1 | Dedicated VP receive pin |
| vm_out | output | 1 | Dedicated VM receive pin |
| rcv_out | output | 1 | Dedicated differential receive pin |
| drv_oe | output | 1 | Line driver enable |
| drv_dp | output | 1 | DP driver data |
| drv_dm | output | 1 | DM driver data |
| xcvr_en | output | 1 | Transceiver enable |
| dm_pulse_out | output | 1 | DM exit pulse, which also reads back as the request bit |

## Verification
The condition hardest to reach from the ports is a pulse request that arrives while a pulse is already running. It needs an audio mode to be loaded first, then a strobe, then a second strobe timed some cycles into the pulse. The bench does this in a directed sequence and measures the total high time against `PULSE_CYC`. The combinational steering is covered by a vector table that sweeps each style and bus mode with receiver patterns chosen so that each output bit differs from its neighbours.

// File: rtl/usb_xcvr_if_ctl.sv
module usb_xcvr_if_ctl #(
  parameter int PULSE_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [2:0] mode_wdata,
  input  logic       cfg_se0_style,
  input  logic       cfg_bidir,
  input  logic       txen_n,
  input  logic       dat_vp_in,
  input  logic       se0_vm_in,
  input  logic       rx_dp,
  input  logic       rx_dm,
  input  logic       rx_diff,
  input  logic       dm_pulse_set,
  output logic       dat_vp_out,
  output logic       dat_vp_oe,
  output logic       se0_vm_out,
  output logic       se0_vm_oe,
  output logic       vp_out,
  output logic       vm_out,
  output logic       rcv_out,
  output logic       drv_oe,
  output logic       drv_dp,
  output logic       drv_dm,
  output logic       xcvr_en,
  output logic       dm_pulse_out
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [2:0]    mode_q;
  logic          pulse_q;
  logic [CW-1:0] pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 3'b000;
    else if (mode_we) mode_q <= mode_wdata;
  end

  logic uart_m, audio_m, loop_m;
  assign xcvr_en = rst_n && (mode_q == 3'b000);
  assign uart_m  = (mode_q == 3'b001) || (mode_q == 3'b010);
  assign audio_m = (mode_q == 3'b100) || (mode_q == 3'b101);
  assign loop_m  = (mode_q[2:1] == 2'b11);

  logic rx_oe, se0_seen, tx_se0;
  assign rx_oe    = xcvr_en && cfg_bidir && txen_n;
  assign se0_seen = !rx_dp && !rx_dm;
  assign tx_se0   = cfg_se0_style && se0_vm_in;

  assign dat_vp_oe  = rx_oe;
  assign se0_vm_oe  = rx_oe;
  assign dat_vp_out = rx_oe && rx_dp;
  assign se0_vm_out = rx_oe && (cfg_se0_style ? se0_seen : rx_dm);

  always_comb begin
    if (loop_m) begin
      vp_out = dat_vp_in;
      vm_out = se0_vm_in;
    end else if (xcvr_en || uart_m) begin
      vp_out = rx_dp;
      vm_out = rx_dm;
    end else begin
      vp_out = 1'b0;
      vm_out = 1'b0;
    end
  end
  assign rcv_out = xcvr_en && rx_diff;

  assign drv_oe = xcvr_en && !txen_n;
  assign drv_dp = drv_oe && dat_vp_in && !tx_se0;
  assign drv_dm = drv_oe && (cfg_se0_style ? (!dat_vp_in && !tx_se0) : se0_vm_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q   <= 1'b0;
      pulse_cnt <= '0;
    end else if (pulse_q) begin
      if (pulse_cnt == '0) pulse_q <= 1'b0;
      else                 pulse_cnt <= pulse_cnt - 1'b1;
    end else if (dm_pulse_set && audio_m) begin
      pulse_q   <= 1'b1;
      pulse_cnt <= CW'(PULSE_CYC - 1);
    end
  end
  assign dm_pulse_out = pulse_q;
endmodule

// File: rtl/usb_xcvr_if_ctl_chk.sv
module usb_xcvr_if_ctl_chk #(
  parameter int PULSE_CYC = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_q,
  input logic       mode_we,
  input logic [2:0] mode_wdata,
  input logic       cfg_bidir,
  input logic       cfg_se0_style,
  input logic       se0_vm_in,
  input logic       dat_vp_oe,
  input logic       se0_vm_oe,
  input logic       drv_oe,
  input logic       drv_dp,
  input logic       drv_dm,
  input logic       xcvr_en,
  input logic       dm_pulse_set,
  input logic       dm_pulse_out
);
  localparam int RW = $clog2(PULSE_CYC + 2);
  logic [RW-1:0] run_len;
  logic in_audio;
  assign in_audio = (mode_q == 3'b100) || (mode_q == 3'b101);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_len <= '0;
    else if (dm_pulse_out) run_len <= run_len + 1'b1;
    else                   run_len <= '0;
  end

  AST_MODE_LEAVES_USB: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_wdata != 3'b000) |=> !xcvr_en);  // R1
  AST_UNIDIR_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bidir |-> (!dat_vp_oe && !se0_vm_oe));  // R4
  AST_DRV_USB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_oe || drv_dp || drv_dm) |-> xcvr_en);  // R8
  AST_SE0_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_oe && cfg_se0_style && se0_vm_in) |-> (!drv_dp && !drv_dm));  // R7
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_pulse_set && in_audio && !dm_pulse_out) |=> dm_pulse_out);  // R12
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dm_pulse_out) |-> (run_len == RW'(PULSE_CYC)));  // R12
  AST_PULSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_pulse_set && !in_audio && !dm_pulse_out) |=> !dm_pulse_out);  // R13
endmodule

bind usb_xcvr_if_ctl usb_xcvr_if_ctl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .mode_we(mode_we),
  .mode_wdata(mode_wdata), .cfg_bidir(cfg_bidir), .cfg_se0_style(cfg_se0_style),
  .se0_vm_in(se0_vm_in), .dat_vp_oe(dat_vp_oe), .se0_vm_oe(se0_vm_oe),
  .drv_oe(drv_oe), .drv_dp(drv_dp), .drv_dm(drv_dm), .xcvr_en(xcvr_en),
  .dm_pulse_set(dm_pulse_set), .dm_pulse_out(dm_pulse_out)
);

// File: tb/usb_xcvr_if_ctl_tb.sv
module usb_xcvr_if_ctl_tb;
  localparam int PULSE_CYC = 40;
  localparam int NV = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 1'b0;
  logic [2:0] mode_wdata = 3'b000;
  logic cfg_se0_style = 1'b0, cfg_bidir = 1'b1, txen_n = 1'b1;
  logic dat_vp_in = 1'b0, se0_vm_in = 1'b0;
  logic rx_dp = 1'b0, rx_dm = 1'b0, rx_diff = 1'b0, dm_pulse_set = 1'b0;
  logic dat_vp_out, dat_vp_oe, se0_vm_out, se0_vm_oe, vp_out, vm_out, rcv_out;
  logic drv_oe, drv_dp, drv_dm, xcvr_en, dm_pulse_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usb_xcvr_if_ctl #(.PULSE_CYC(PULSE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cfg_se0_style(cfg_se0_style), .cfg_bidir(cfg_bidir), .txen_n(txen_n),
    .dat_vp_in(dat_vp_in), .se0_vm_in(se0_vm_in), .rx_dp(rx_dp), .rx_dm(rx_dm),
    .rx_diff(rx_diff), .dm_pulse_set(dm_pulse_set), .dat_vp_out(dat_vp_out),
    .dat_vp_oe(dat_vp_oe), .se0_vm_out(se0_vm_out), .se0_vm_oe(se0_vm_oe),
    .vp_out(vp_out), .vm_out(vm_out), .rcv_out(rcv_out), .drv_oe(drv_oe),
    .drv_dp(drv_dp), .drv_dm(drv_dm), .xcvr_en(xcvr_en), .dm_pulse_out(dm_pulse_out)
  );

  // {mode, style, bidir, txen_n, dat, se0, dp, dm, diff,
  //  exp: dvo, doe, svo, soe, vp, vm, rcv, drv_oe, drv_dp, drv_dm}
  localparam logic [20:0] VEC [NV] = '{
    21'b000_0_1_1_0_0_1_0_1_1101101000, // R2 R5
    21'b000_0_1_1_1_1_0_1_0_0111010000, // R2 R5
    21'b000_1_1_1_0_0_0_0_0_0111000000, // R3 SE0 seen
    21'b000_1_1_1_0_0_1_0_1_1101101000, // R3
    21'b000_0_0_1_1_1_1_0_1_0000101000, // R4
    21'b000_1_0_1_0_0_0_1_0_0000010000, // R4
    21'b000_0_1_0_1_0_0_1_1_0000011110, // R6 R5
    21'b000_0_0_0_0_1_1_1_0_0000110101, // R6
    21'b000_1_1_0_1_0_0_0_0_0000000110, // R7
    21'b000_1_0_0_0_0_0_0_0_0000000101, // R7
    21'b000_1_0_0_1_1_0_0_0_0000000100, // R7 SE0 transmit
    21'b001_0_1_0_1_0_1_0_1_0000100000, // R9 R8
    21'b010_1_1_1_0_0_0_1_1_0000010000, // R9
    21'b100_0_1_1_1_1_1_1_1_0000000000, // R10
    21'b101_1_0_0_1_0_1_0_1_0000000000, // R10 R8
    21'b011_0_1_0_1_1_1_1_1_0000000000, // R10 unused code
    21'b110_0_1_1_1_0_0_1_0_0000100000, // R11
    21'b111_1_0_0_0_1_1_0_1_0000010000  // R11
  };
  localparam int VREQ [NV] = '{2,2,3,3,4,4,6,6,7,7,7,9,9,10,10,10,11,11};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic measure_pulse(output int hi);
    hi = 0;
    for (int k = 0; k < 3 * PULSE_CYC; k++) begin
      @(negedge clk);
      if (dm_pulse_out) hi++;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    chk("R1 reset xcvr_en", {15'd0, xcvr_en}, 16'd0);
    chk("R12 reset pulse", {15'd0, dm_pulse_out}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 usb after reset", {15'd0, xcvr_en}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      set_mode(VEC[i][20:18]);
      {cfg_se0_style, cfg_bidir, txen_n, dat_vp_in, se0_vm_in, rx_dp, rx_dm, rx_diff} = VEC[i][17:10];
      #1;
      chk($sformatf("R%0d vector %0d", VREQ[i], i),
          {6'd0, dat_vp_out, dat_vp_oe, se0_vm_out, se0_vm_oe, vp_out, vm_out,
           rcv_out, drv_oe, drv_dp, drv_dm}, {6'd0, VEC[i][9:0]});
    end

    set_mode(3'b001);
    chk("R1 non-usb disables", {15'd0, xcvr_en}, 16'd0);
    set_mode(3'b000);
    chk("R1 usb re-enables", {15'd0, xcvr_en}, 16'd1);

    // R13: request outside audio
    @(negedge clk); dm_pulse_set = 1'b1;
    @(negedge clk); dm_pulse_set = 1'b0;
    measure_pulse(hi);
    chk("R13 ignored in usb", hi[15:0], 16'd0);

    // R12: single pulse in mono audio
    set_mode(3'b100);
    @(negedge clk); dm_pulse_set = 1'b1;
    @(negedge clk); dm_pulse_set = 1'b0;
    chk("R12 pulse starts", {15'd0, dm_pulse_out}, 16'd1);
    hi = 1;
    for (int k = 0; k < 3 * PULSE_CYC; k++) begin
      @(negedge clk);
      if (dm_pulse_out) hi++;
    end
    chk("R12 pulse width", hi[15:0], 16'(PULSE_CYC));
    chk("R12 self clear", {15'd0, dm_pulse_out}, 16'd0);

    // R13: second request during a running pulse (stereo audio)
    set_mode(3'b101);
    @(negedge clk); dm_pulse_set = 1'b1;
    @(negedge clk); dm_pulse_set = 1'b0;
    hi = dm_pulse_out ? 1 : 0;
    repeat (9) begin @(negedge clk); if (dm_pulse_out) hi++; end
    dm_pulse_set = 1'b1;
    @(negedge clk); dm_pulse_set = 1'b0;
    if (dm_pulse_out) hi++;
    for (int k = 0; k < 3 * PULSE_CYC; k++) begin
      @(negedge clk);
      if (dm_pulse_out) hi++;
    end
    chk("R13 no extension", hi[15:0], 16'(PULSE_CYC));

    finish_run();
  end
endmodule